// File: doc/BRIEF.md
# Multi-Region Column Control Word Generator

This block prepares the per-column control words for a 256-column imager array that reads up to three rectangular regions of interest at once. Each region is described by a first column, a column count and a super-pixel size that is a power of two from 1 to 32. For every column, the block decides whether it lies inside each region. It then marks where each averaging group begins and ends, counting from the region's own first column rather than from a fixed grid. From these it derives six control bits per column and region.

Region 0 drives a dedicated control port (port A). Regions 1 and 2 share a second port (port B), and region 1 wins any column that both claim. A separate column-enable line is high only for columns inside some region, so that idle columns can have their sampling stage powered down.

Software writes region settings through a valid/ready configuration channel. It issues `load` to start generation. `ready` rises after a fixed two-cycle computation. An `apply` strobe then moves the whole result into the output latches in one edge, so every column changes together.

Top module: `roi_colctl_gen`

## Requirements
- R1: After reset, `ready` is 0, `cfg_ready` is 1, and `col_ctl_a`, `col_ctl_b`, `col_en` and `ovl_err` are all zero. Every region's width resets to 0.
- R2: A configuration beat is taken on a clock edge where `cfg_valid` and `cfg_ready` are both 1. It writes `cfg_start`, `cfg_width` and `cfg_size` into the region named by `cfg_sel`; a value of 3 is dropped. `cfg_ready` is 0 for exactly the one cycle after an accepted `load`, and a beat offered then is not taken. `load` is accepted only while `cfg_ready` is 1, and it captures the region settings held before that edge.
- R3: `ready` is 1 starting with the second clock edge after an accepted `load`. It stays 1 until the next accepted `load`. Outputs do not change while `ready` waits.
- R4: Outputs change only on an edge where `apply` and `ready` are both 1, and then all of them change together. `apply` while `ready` is 0 leaves every output unchanged.
- R5: A region covers the columns from `start` to min(`start`+`width`-1, 255). A width of 0 covers nothing. Bit 0 of a column word is 1 exactly for covered columns.
- R6: With size S, bit 1 (group start) is set on covered columns where (column−start) mod S = 0. Bit 2 (group end) is set on covered columns where (column−start) mod S = S−1, or on the region's last covered column. Bit 5 (readout select) equals bit 1.
- R7: Bit 3 (column-average enable) is set on covered columns that are not a group end. Bit 4 (row-average enable) is set on covered columns when S > 1. Size codes 0..5 give S = 1,2,4,8,16,32, and codes 6 and 7 give S = 32.
- R8: Port A carries region 0's words. Port B carries region 1's word on columns that region 1 covers, and region 2's word elsewhere. `ovl_err` is 1 when regions 1 and 2 share at least one column.
- R9: `col_en[c]` is 1 exactly when column c is covered by at least one of the three regions.
- R10: Region 0 may overlap regions 1 or 2 freely. Such overlap changes neither port B nor `ovl_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration beat offered |
| cfg_ready | output | 1 | Configuration channel and `load` accepted |
| cfg_sel | input | 2 | Target region 0..2 |
| cfg_start | input | 8 | First column of the region |
| cfg_width | input | 9 | Column count, 0..256 or more (clamped) |
| cfg_size | input | 3 | Super-pixel size code, S = 2^code |
| load | input | 1 | Start generation from current settings |
| apply | input | 1 | Transfer finished result to outputs |
| ready | output | 1 | Result waiting to be applied |
| col_ctl_a | output | 1536 | Port A words, column c at bits [6c+5:6c] |
| col_ctl_b | output | 1536 | Port B merged words, same layout |
| col_en | output | 256 | Column sampling enable |
| ovl_err | output | 1 | Regions 1 and 2 overlap |

## Verification
A corrupted membership parity would show as a run of wrong bit-0 and `col_en` values. That run starts at a start or end mark and continues to the far edge of the array, and it appears on the first `apply` after the faulty `load`. A wrong group offset or size decode shifts the group-start, group-end and readout bits within a region, which a full-word comparison of every column catches on that same `apply`. A mistake in the handshake state shows within two cycles of `load`: `ready`, `cfg_ready` or an output changes on the wrong edge.

// File: rtl/roi_ctl_pkg.sv
package roi_ctl_pkg;
  localparam int CTL_W       = 6;
  localparam int B_IN        = 0;
  localparam int B_GSTART    = 1;
  localparam int B_GEND      = 2;
  localparam int B_CAVG      = 3;
  localparam int B_RAVG      = 4;
  localparam int B_RSEL      = 5;
  localparam int SZ_W        = 3;
  localparam int SZ_LOG_MAX  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } gen_state_t;

  function automatic logic [SZ_W-1:0] size_log(input logic [SZ_W-1:0] code);
    return (int'(code) > SZ_LOG_MAX) ? SZ_W'(SZ_LOG_MAX) : code;
  endfunction
endpackage

// File: rtl/roi_mask.sv
module roi_mask #(
  parameter int NCOL = 256,
  localparam int AW = $clog2(NCOL),
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0]   start,
  input  logic [AW:0]     width,
  output logic [NCOL-1:0] member
);
  logic [EW-1:0] stop;
  logic          active;
  logic [NCOL-1:0] mark;

  assign stop   = EW'(start) + EW'(width);
  assign active = |width;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      mark[c] = active && ((start == AW'(c)) ^ (stop == EW'(c)));
    end
  end

  always_comb begin
    logic parity;
    parity = 1'b0;
    for (int c = 0; c < NCOL; c++) begin
      parity    = parity ^ mark[c];
      member[c] = parity;
    end
  end
endmodule

// File: rtl/roi_pattern.sv
module roi_pattern
  import roi_ctl_pkg::*;
#(
  parameter int NCOL = 256,
  localparam int AW = $clog2(NCOL),
  localparam int EW = AW + 2,
  localparam int WW = NCOL * CTL_W
) (
  input  logic [AW-1:0]   start,
  input  logic [AW:0]     width,
  input  logic [SZ_W-1:0] size_code,
  input  logic [NCOL-1:0] member,
  output logic [WW-1:0]   words
);
  logic [EW-1:0]   stop;
  logic [EW-1:0]   last_col;
  logic [SZ_W-1:0] lg;
  logic [AW-1:0]   gmask;

  assign stop     = EW'(start) + EW'(width);
  assign last_col = (stop > EW'(NCOL)) ? EW'(NCOL - 1) : stop - EW'(1);
  assign lg       = size_log(size_code);
  assign gmask    = AW'((32'd1 << lg) - 32'd1);

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      logic [AW-1:0] off;
      logic [AW-1:0] pos;
      logic          m, gs, ge;
      off = AW'(c) - start;
      pos = off & gmask;
      m   = member[c];
      gs  = m && (pos == '0);
      ge  = m && ((pos == gmask) || (EW'(c) == last_col));
      words[c*CTL_W + B_IN]     = m;
      words[c*CTL_W + B_GSTART] = gs;
      words[c*CTL_W + B_GEND]   = ge;
      words[c*CTL_W + B_CAVG]   = m && !ge;
      words[c*CTL_W + B_RAVG]   = m && (lg != '0);
      words[c*CTL_W + B_RSEL]   = gs;
    end
  end
endmodule

// File: rtl/port_merge.sv
module port_merge
  import roi_ctl_pkg::*;
#(
  parameter int NCOL = 256,
  localparam int WW = NCOL * CTL_W
) (
  input  logic [WW-1:0] w_pri,
  input  logic [WW-1:0] w_sec,
  output logic [WW-1:0] w_out,
  output logic          collide
);
  logic [NCOL-1:0] both;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      logic pri_in, sec_in;
      pri_in  = w_pri[c*CTL_W + B_IN];
      sec_in  = w_sec[c*CTL_W + B_IN];
      both[c] = pri_in && sec_in;
      w_out[c*CTL_W +: CTL_W] = pri_in ? w_pri[c*CTL_W +: CTL_W]
                                       : w_sec[c*CTL_W +: CTL_W];
    end
  end

  assign collide = |both;
endmodule

// File: rtl/roi_colctl_gen.sv
module roi_colctl_gen
  import roi_ctl_pkg::*;
#(
  parameter int NCOL = 256,
  localparam int AW = $clog2(NCOL),
  localparam int WW = NCOL * CTL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_start,
  input  logic [AW:0]     cfg_width,
  input  logic [SZ_W-1:0] cfg_size,
  input  logic            load,
  input  logic            apply,
  output logic            ready,
  output logic [WW-1:0]   col_ctl_a,
  output logic [WW-1:0]   col_ctl_b,
  output logic [NCOL-1:0] col_en,
  output logic            ovl_err
);
  localparam int NREG = 3;

  gen_state_t state_q;

  logic [AW-1:0]   cfg_start_q [NREG];
  logic [AW:0]     cfg_width_q [NREG];
  logic [SZ_W-1:0] cfg_size_q  [NREG];
  logic [AW-1:0]   snap_start  [NREG];
  logic [AW:0]     snap_width  [NREG];
  logic [SZ_W-1:0] snap_size   [NREG];

  logic [NCOL-1:0] member [NREG];
  logic [WW-1:0]   words  [NREG];
  logic [WW-1:0]   merged_b;
  logic            collide_b;

  logic [WW-1:0]   stage_a, stage_b;
  logic [NCOL-1:0] stage_en;
  logic            stage_ovl;

  logic load_ok, apply_ok;

  assign cfg_ready = (state_q != ST_BUSY);
  assign ready     = (state_q == ST_DONE);
  assign load_ok   = load && cfg_ready;
  assign apply_ok  = apply && ready;

  // Region settings and snapshots
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        cfg_start_q[r] <= '0;
        cfg_width_q[r] <= '0;
        cfg_size_q[r]  <= '0;
        snap_start[r]  <= '0;
        snap_width[r]  <= '0;
        snap_size[r]   <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (load_ok) begin
          snap_start[r] <= cfg_start_q[r];
          snap_width[r] <= cfg_width_q[r];
          snap_size[r]  <= cfg_size_q[r];
        end
        if (cfg_valid && cfg_ready && (cfg_sel == 2'(r))) begin
          cfg_start_q[r] <= cfg_start;
          cfg_width_q[r] <= cfg_width;
          cfg_size_q[r]  <= cfg_size;
        end
      end
    end
  end

  // Per-region membership and pattern
  for (genvar r = 0; r < NREG; r++) begin : g_region
    roi_mask #(.NCOL(NCOL)) u_mask (
      .start  (snap_start[r]),
      .width  (snap_width[r]),
      .member (member[r])
    );
    roi_pattern #(.NCOL(NCOL)) u_pat (
      .start     (snap_start[r]),
      .width     (snap_width[r]),
      .size_code (snap_size[r]),
      .member    (member[r]),
      .words     (words[r])
    );
  end

  port_merge #(.NCOL(NCOL)) u_merge (
    .w_pri   (words[1]),
    .w_sec   (words[2]),
    .w_out   (merged_b),
    .collide (collide_b)
  );

  // Sequencing, staging and output latches
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stage_a   <= '0;
      stage_b   <= '0;
      stage_en  <= '0;
      stage_ovl <= 1'b0;
      col_ctl_a <= '0;
      col_ctl_b <= '0;
      col_en    <= '0;
      ovl_err   <= 1'b0;
    end else begin
      if (load_ok) begin
        state_q <= ST_BUSY;
      end else if (state_q == ST_BUSY) begin
        state_q   <= ST_DONE;
        stage_a   <= words[0];
        stage_b   <= merged_b;
        stage_en  <= member[0] | member[1] | member[2];
        stage_ovl <= collide_b;
      end
      if (apply_ok) begin
        col_ctl_a <= stage_a;
        col_ctl_b <= stage_b;
        col_en    <= stage_en;
        ovl_err   <= stage_ovl;
      end
    end
  end
endmodule

// File: rtl/roi_colctl_chk.sv
module roi_colctl_chk
  import roi_ctl_pkg::*;
#(
  parameter int NCOL = 256,
  localparam int AW = $clog2(NCOL),
  localparam int WW = NCOL * CTL_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_ready,
  input logic            load,
  input logic            apply,
  input logic            ready,
  input logic [WW-1:0]   col_ctl_a,
  input logic [WW-1:0]   col_ctl_b,
  input logic [NCOL-1:0] col_en,
  input logic            ovl_err
);
  logic [NCOL-1:0] in_a, in_b, gs_a, gs_b, rs_a, rs_b, ge_a, ca_a;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      in_a[c] = col_ctl_a[c*CTL_W + B_IN];
      in_b[c] = col_ctl_b[c*CTL_W + B_IN];
      gs_a[c] = col_ctl_a[c*CTL_W + B_GSTART];
      gs_b[c] = col_ctl_b[c*CTL_W + B_GSTART];
      rs_a[c] = col_ctl_a[c*CTL_W + B_RSEL];
      rs_b[c] = col_ctl_b[c*CTL_W + B_RSEL];
      ge_a[c] = col_ctl_a[c*CTL_W + B_GEND];
      ca_a[c] = col_ctl_a[c*CTL_W + B_CAVG];
    end
  end

  // R2
  load_locks_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_ready) |=> (!cfg_ready && !ready));

  // R3
  ready_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(load, 2));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply && ready) |=> ($stable(col_ctl_a) && $stable(col_ctl_b)
                           && $stable(col_en) && $stable(ovl_err)));

  // R9
  col_en_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_en == (in_a | in_b));

  // R6
  rsel_gstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_a == gs_a) && (rs_b == gs_b) && ((gs_a & ~in_a) == '0));

  // R7
  cavg_not_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_a & ge_a) == '0);
endmodule

bind roi_colctl_gen roi_colctl_chk #(.NCOL(NCOL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_ready (cfg_ready),
  .load      (load),
  .apply     (apply),
  .ready     (ready),
  .col_ctl_a (col_ctl_a),
  .col_ctl_b (col_ctl_b),
  .col_en    (col_en),
  .ovl_err   (ovl_err)
);

// File: tb/test_roi_colctl_gen.sv
module test_roi_colctl_gen;
  localparam int NCOL = 256;
  localparam int AW   = 8;
  localparam int CW   = 6;
  localparam int WW   = NCOL * CW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_valid = 1'b0;
  logic            cfg_ready;
  logic [1:0]      cfg_sel = '0;
  logic [AW-1:0]   cfg_start = '0;
  logic [AW:0]     cfg_width = '0;
  logic [2:0]      cfg_size = '0;
  logic            load = 1'b0;
  logic            apply = 1'b0;
  logic            ready;
  logic [WW-1:0]   col_ctl_a, col_ctl_b;
  logic [NCOL-1:0] col_en;
  logic            ovl_err;

  int n_tests = 0;
  int n_fail  = 0;

  int m_start [3], m_width [3], m_size [3];
  int s_start [3], s_width [3], s_size [3];
  logic [WW-1:0]   ex_a, ex_b;
  logic [NCOL-1:0] ex_en;
  logic            ex_ovl;

  always #10 clk = ~clk;

  roi_colctl_gen #(.NCOL(NCOL)) i_roi_colctl_gen (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_sel(cfg_sel), .cfg_start(cfg_start), .cfg_width(cfg_width),
    .cfg_size(cfg_size), .load(load), .apply(apply), .ready(ready),
    .col_ctl_a(col_ctl_a), .col_ctl_b(col_ctl_b), .col_en(col_en),
    .ovl_err(ovl_err)
  );

  function automatic logic [5:0] exp_word(int c, int s, int w, int code);
    int sz, last, pos;
    logic gs, ge;
    sz = (code > 5) ? 32 : (1 << code);
    if (w == 0) return 6'b0;
    last = s + w - 1;
    if (last > NCOL - 1) last = NCOL - 1;
    if (c < s || c > last) return 6'b0;
    pos = (c - s) % sz;
    gs  = (pos == 0);
    ge  = (pos == sz - 1) || (c == last);
    return {gs, sz > 1, !ge, ge, gs, 1'b1};
  endfunction

  task automatic compute_expected();
    ex_ovl = 1'b0;
    for (int c = 0; c < NCOL; c++) begin
      logic [5:0] w0, w1, w2;
      w0 = exp_word(c, s_start[0], s_width[0], s_size[0]);
      w1 = exp_word(c, s_start[1], s_width[1], s_size[1]);
      w2 = exp_word(c, s_start[2], s_width[2], s_size[2]);
      ex_a[c*CW +: CW] = w0;
      ex_b[c*CW +: CW] = w1[0] ? w1 : w2;
      ex_en[c] = w0[0] | w1[0] | w2[0];
      if (w1[0] && w2[0]) ex_ovl = 1'b1;
    end
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    int bad_a, bad_b, bad_e, fa, fb, fe;
    bad_a = 0; bad_b = 0; bad_e = 0; fa = -1; fb = -1; fe = -1;
    for (int c = 0; c < NCOL; c++) begin
      if (col_ctl_a[c*CW +: CW] !== ex_a[c*CW +: CW]) begin bad_a++; if (fa < 0) fa = c; end
      if (col_ctl_b[c*CW +: CW] !== ex_b[c*CW +: CW]) begin bad_b++; if (fb < 0) fb = c; end
      if (col_en[c] !== ex_en[c]) begin bad_e++; if (fe < 0) fe = c; end
    end
    n_tests += 4;
    if (bad_a != 0) begin
      n_fail++;
      $display("FAIL %s port A col %0d: actual %b expected %b", req, fa,
               col_ctl_a[fa*CW +: CW], ex_a[fa*CW +: CW]);
    end
    if (bad_b != 0) begin
      n_fail++;
      $display("FAIL %s port B col %0d: actual %b expected %b", req, fb,
               col_ctl_b[fb*CW +: CW], ex_b[fb*CW +: CW]);
    end
    if (bad_e != 0) begin
      n_fail++;
      $display("FAIL %s R9 col_en col %0d: actual %b expected %b", req, fe,
               col_en[fe], ex_en[fe]);
    end
    if (ovl_err !== ex_ovl) begin
      n_fail++;
      $display("FAIL %s R8 ovl_err: actual %b expected %b", req, ovl_err, ex_ovl);
    end
  endtask

  task automatic write_cfg(int sel, int s, int w, int code);
    cfg_valid = 1'b1; cfg_sel = 2'(sel); cfg_start = AW'(s);
    cfg_width = (AW+1)'(w); cfg_size = 3'(code);
    @(posedge clk);
    if (cfg_ready && sel < 3) begin
      m_start[sel] = s; m_width[sel] = w; m_size[sel] = code;
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic do_load();
    load = 1'b1;
    @(posedge clk);
    for (int r = 0; r < 3; r++) begin
      s_start[r] = m_start[r]; s_width[r] = m_width[r]; s_size[r] = m_size[r];
    end
    @(negedge clk);
    load = 1'b0;
    chk("R2", "cfg_ready one cycle after load", cfg_ready, 0);
    chk("R3", "ready one cycle after load", ready, 0);
    @(negedge clk);
    chk("R3", "ready two cycles after load", ready, 1);
    chk("R2", "cfg_ready back after generation", cfg_ready, 1);
  endtask

  task automatic do_apply();
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    compute_expected();
  endtask

  task automatic run_case(string req);
    do_load();
    do_apply();
    check_outs(req);
  endtask

  task automatic t_reset();
    chk("R1", "ready", ready, 0);
    chk("R1", "cfg_ready", cfg_ready, 1);
    chk("R1", "col_en nonzero", (col_en != '0), 0);
    chk("R1", "port A nonzero", (col_ctl_a != '0), 0);
    chk("R1", "port B nonzero", (col_ctl_b != '0), 0);
    chk("R1", "ovl_err", ovl_err, 0);
  endtask

  task automatic t_single();
    write_cfg(0, 10, 20, 2);
    do_load();
    @(negedge clk);
    chk("R3", "outputs held while ready waits", (col_en != '0), 0);
    do_apply();
    check_outs("R5 R6 R7 single region");
  endtask

  task automatic t_sizes();
    for (int code = 0; code < 8; code++) begin
      write_cfg(0, 5 + code * 7, 45, code);
      run_case("R6 R7 size sweep");
    end
  endtask

  task automatic t_clamp();
    write_cfg(0, 250, 40, 5);
    run_case("R5 end clamp");
    write_cfg(0, 0, 256, 3);
    run_case("R5 full width");
  endtask

  task automatic t_zero();
    write_cfg(0, 30, 0, 1);
    write_cfg(1, 60, 0, 2);
    write_cfg(2, 90, 0, 3);
    run_case("R5 zero width");
    chk("R9", "col_en empty for zero width", (col_en != '0), 0);
  endtask

  task automatic t_merge();
    write_cfg(1, 0, 64, 4);
    write_cfg(2, 100, 30, 1);
    write_cfg(0, 40, 80, 3);
    run_case("R8 R10 disjoint port B, region 0 overlapping");
    chk("R10", "no error from region 0 overlap", ovl_err, 0);
  endtask

  task automatic t_overlap();
    write_cfg(2, 50, 40, 0);
    run_case("R8 overlap priority");
    chk("R8", "overlap flag", ovl_err, 1);
  endtask

  task automatic t_ignore();
    write_cfg(0, 17, 9, 1);
    write_cfg(3, 200, 30, 2);
    load = 1'b1;
    @(posedge clk);
    for (int r = 0; r < 3; r++) begin
      s_start[r] = m_start[r]; s_width[r] = m_width[r]; s_size[r] = m_size[r];
    end
    @(negedge clk);
    load = 1'b0;
    apply = 1'b1;
    cfg_valid = 1'b1; cfg_sel = 2'd0; cfg_start = 8'd0; cfg_width = 9'd0; cfg_size = 3'd0;
    @(negedge clk);
    apply = 1'b0;
    cfg_valid = 1'b0;
    check_outs("R4 apply before ready ignored");
    chk("R3", "ready after ignored apply", ready, 1);
    do_apply();
    check_outs("R4 apply after ready, R2 sel 3 dropped");
    run_case("R2 write during busy dropped");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 3; r++) begin
      m_start[r] = 0; m_width[r] = 0; m_size[r] = 0;
    end
    @(negedge clk);
    t_reset();
    t_single();
    t_sizes();
    t_clamp();
    t_zero();
    t_merge();
    t_overlap();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule